// File: doc/BRIEF.md
# Three-Slot Bundle Decoder with Template Steering

This block accepts one 128-bit wide-issue instruction bundle per transfer and breaks it into a 5-bit template and three 41-bit slot words. The slot words are passed through unchanged; their opcodes are not examined. Only the template decides which execution-unit class receives each slot. It also decides where a group of instructions that may issue together ends. That end can fall after slot 0, after slot 1, or at the end of the bundle.

The decoder sits between fetch and dispersal. It has one register stage with a valid/ready handshake on both sides. While downstream stalls, the registered result is held. A template from the reserved range raises an illegal flag and suppresses every slot.

Top module: `bundle_decoder`

## Requirements
- R1: The template is bundle bits [4:0]. Slot 0 is bits [45:5], slot 1 is bits [86:46] and slot 2 is bits [127:87]. On `out_slot`, slot i appears at bits [41*i+40 : 41*i].
- R2: Unit codes are 2 bits: 0 = integer ALU, 1 = memory, 2 = floating point, 3 = branch. On `out_unit`, slot i's code is at bits [2i+1:2i]. Template bits [4:1] form a pattern p, listed here as (slot0, slot1, slot2):
  - p0 = ALU,ALU,ALU
  - p1 = MEM,ALU,ALU
  - p2 = MEM,MEM,ALU
  - p3 = MEM,ALU,BR
  - p4 = MEM,FP,ALU
  - p5 = MEM,MEM,FP
  - p6 = MEM,FP,BR
  - p7 = ALU,ALU,BR
  - p8 = MEM,BR,BR
  - p9 = BR,BR,BR
  - p10 = MEM,ALU,ALU
  - p11 = MEM,MEM,ALU
  - p12 = FP,FP,BR
- R3: For a legal template, `out_stop[2]` (group ends after slot 2) equals template bit 0.
- R4: `out_stop[1]` is set only for pattern 10 and `out_stop[0]` only for pattern 11. At most one of the two is ever set.
- R5: Patterns 13 to 15 (templates 26 to 31) are reserved. For these, `out_illegal` is 1 and `out_slot_vld`, `out_stop` and `out_unit` are all zero. The slot words still pass through.
- R6: For a legal template, `out_illegal` is 0 and all three bits of `out_slot_vld` are 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged on the next cycle.
- R8: `in_ready` equals `out_ready` OR NOT `out_valid`.
- R9: A bundle accepted at a clock edge is presented on the outputs right after that edge. With `out_ready` held at 1, one bundle is accepted on every cycle.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Decoder can take a bundle |
| in_bundle | input | 128 | Incoming bundle |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Downstream takes the result |
| out_slot | output | 123 | Three slot words, slot 0 lowest |
| out_unit | output | 6 | Unit code per slot |
| out_slot_vld | output | 3 | Per-slot valid |
| out_stop | output | 3 | Group ends after this slot |
| out_illegal | output | 1 | Reserved template seen |

## Verification
The hardest situation to reach is a stall that arrives exactly as a new bundle is waiting. In that case the held result must not change while `in_ready` drops. The bench drives `out_ready` from a random value that changes every cycle. It also offers bundles with random gaps, so that acceptance, hold and release occur in every order. Before that random phase, a directed sweep walks all 32 templates back to back with `out_ready` high. This sweep covers the two mid-bundle stop patterns and the reserved range, and it checks single-cycle throughput.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int NSLOT  = 3;
  localparam int TMPL_W = 5;
  localparam int UNIT_W = 2;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_ALU = 2'd0,
    UNIT_MEM = 2'd1,
    UNIT_FP  = 2'd2,
    UNIT_BR  = 2'd3
  } unit_e;

  typedef struct packed {
    logic                    illegal;
    logic [NSLOT-1:0]        stop;
    logic [NSLOT*UNIT_W-1:0] units;
  } tmpl_info_t;

  function automatic logic [NSLOT*UNIT_W-1:0] pack_units(unit_e s0, unit_e s1, unit_e s2);
    return {s2, s1, s0};
  endfunction

  function automatic tmpl_info_t tmpl_lookup(logic [TMPL_W-1:0] t);
    tmpl_info_t r;
    logic [TMPL_W-2:0] p;
    p = t[TMPL_W-1:1];
    r = '0;
    case (p)
      4'd0:  r.units = pack_units(UNIT_ALU, UNIT_ALU, UNIT_ALU);
      4'd1:  r.units = pack_units(UNIT_MEM, UNIT_ALU, UNIT_ALU);
      4'd2:  r.units = pack_units(UNIT_MEM, UNIT_MEM, UNIT_ALU);
      4'd3:  r.units = pack_units(UNIT_MEM, UNIT_ALU, UNIT_BR);
      4'd4:  r.units = pack_units(UNIT_MEM, UNIT_FP,  UNIT_ALU);
      4'd5:  r.units = pack_units(UNIT_MEM, UNIT_MEM, UNIT_FP);
      4'd6:  r.units = pack_units(UNIT_MEM, UNIT_FP,  UNIT_BR);
      4'd7:  r.units = pack_units(UNIT_ALU, UNIT_ALU, UNIT_BR);
      4'd8:  r.units = pack_units(UNIT_MEM, UNIT_BR,  UNIT_BR);
      4'd9:  r.units = pack_units(UNIT_BR,  UNIT_BR,  UNIT_BR);
      4'd10: begin
        r.units   = pack_units(UNIT_MEM, UNIT_ALU, UNIT_ALU);
        r.stop[1] = 1'b1;
      end
      4'd11: begin
        r.units   = pack_units(UNIT_MEM, UNIT_MEM, UNIT_ALU);
        r.stop[0] = 1'b1;
      end
      4'd12: r.units = pack_units(UNIT_FP, UNIT_FP, UNIT_BR);
      default: r.illegal = 1'b1;
    endcase
    if (!r.illegal) r.stop[NSLOT-1] = t[0];
    return r;
  endfunction
endpackage

// File: rtl/bdec_field_split.sv
module bdec_field_split #(
  parameter int BUNDLE_W = 128,
  parameter int SLOT_W   = 41,
  parameter int TMPL_W   = 5,
  parameter int NSLOT    = 3
) (
  input  logic [BUNDLE_W-1:0]     bundle,
  output logic [TMPL_W-1:0]       tmpl,
  output logic [NSLOT*SLOT_W-1:0] slots
);
  localparam int USED_W = TMPL_W + NSLOT * SLOT_W;

  initial begin
    if (USED_W != BUNDLE_W) $error("bundle width does not match fields");
  end

  assign tmpl = bundle[TMPL_W-1:0];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slots[i*SLOT_W +: SLOT_W] = bundle[TMPL_W + i*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/bdec_template_rom.sv
module bdec_template_rom
  import bdec_pkg::*;
(
  input  logic [TMPL_W-1:0] tmpl,
  output tmpl_info_t        info,
  output logic [NSLOT-1:0]  slot_vld
);
  always_comb begin
    info     = tmpl_lookup(tmpl);
    slot_vld = info.illegal ? '0 : '1;
  end
endmodule

// File: rtl/bdec_out_stage.sv
module bdec_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  assign in_ready  = out_ready | ~valid_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/bundle_decoder.sv
module bundle_decoder
  import bdec_pkg::*;
#(
  parameter int BUNDLE_W = 128,
  parameter int SLOT_W   = 41
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [BUNDLE_W-1:0]        in_bundle,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NSLOT*SLOT_W-1:0]    out_slot,
  output logic [NSLOT*UNIT_W-1:0]    out_unit,
  output logic [NSLOT-1:0]           out_slot_vld,
  output logic [NSLOT-1:0]           out_stop,
  output logic                       out_illegal
);
  localparam int SLOTS_W = NSLOT * SLOT_W;
  localparam int PAY_W   = 1 + 2 * NSLOT + NSLOT * UNIT_W + SLOTS_W;

  logic [TMPL_W-1:0]  tmpl;
  logic [SLOTS_W-1:0] slots;
  tmpl_info_t         info;
  logic [NSLOT-1:0]   slot_vld;
  logic [PAY_W-1:0]   pay_d, pay_q;

  bdec_field_split #(
    .BUNDLE_W(BUNDLE_W), .SLOT_W(SLOT_W), .TMPL_W(TMPL_W), .NSLOT(NSLOT)
  ) i_split (
    .bundle(in_bundle), .tmpl(tmpl), .slots(slots)
  );

  bdec_template_rom i_rom (
    .tmpl(tmpl), .info(info), .slot_vld(slot_vld)
  );

  assign pay_d = {info.illegal, info.stop, slot_vld, info.units, slots};

  bdec_out_stage #(.DW(PAY_W)) i_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_q)
  );

  assign {out_illegal, out_stop, out_slot_vld, out_unit, out_slot} = pay_q;
endmodule

// File: rtl/bundle_decoder_chk.sv
module bundle_decoder_chk #(
  parameter int BUNDLE_W = 128,
  parameter int SLOT_W   = 41
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [BUNDLE_W-1:0]   in_bundle,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [3*SLOT_W-1:0]   out_slot,
  input logic [5:0]            out_unit,
  input logic [2:0]            out_slot_vld,
  input logic [2:0]            out_stop,
  input logic                  out_illegal
);
  localparam int TW = 5;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_slot, out_unit, out_slot_vld, out_stop, out_illegal})); // R7
  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R8
  AST_READY_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_FIELD_MAP: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_slot == $past(in_bundle[BUNDLE_W-1:TW])); // R1
  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_illegal == ($past(in_bundle[TW-1:1]) >= 4'd13)); // R5
  AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> out_slot_vld == 3'b000 && out_stop == 3'b000 && out_unit == 6'd0); // R5
  AST_LEGAL_ALL_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_illegal |-> out_slot_vld == 3'b111); // R6
  AST_END_STOP: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_stop[2] == ($past(in_bundle[0]) && !out_illegal)); // R3
  AST_ONE_MID_STOP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_stop[1:0]) <= 1); // R4
endmodule

bind bundle_decoder bundle_decoder_chk #(.BUNDLE_W(BUNDLE_W), .SLOT_W(SLOT_W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
  .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot), .out_unit(out_unit),
  .out_slot_vld(out_slot_vld), .out_stop(out_stop), .out_illegal(out_illegal)
);

// File: tb/test_bundle_decoder.sv
module test_bundle_decoder;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_bundle = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [122:0] out_slot;
  logic [5:0]   out_unit;
  logic [2:0]   out_slot_vld;
  logic [2:0]   out_stop;
  logic         out_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit rand_ready = 1'b0;
  bit running = 1'b0;
  bit prev_stall = 1'b0;
  logic [135:0] prev_out;
  logic [135:0] exp_q[$];

  always #5 clk = ~clk;

  bundle_decoder i_bundle_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_bundle(in_bundle),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot), .out_unit(out_unit),
    .out_slot_vld(out_slot_vld), .out_stop(out_stop), .out_illegal(out_illegal)
  );

  function automatic logic [5:0] u3(logic [1:0] s0, logic [1:0] s1, logic [1:0] s2);
    return {s2, s1, s0};
  endfunction

  // model: R1 slot fields, R2 unit table, R3/R4 stops, R5 reserved, R6 valids
  function automatic logic [135:0] model(logic [127:0] b);
    logic [3:0] p;
    logic [5:0] u;
    logic [2:0] st;
    logic       ill;
    p = b[4:1];
    st = 3'b000;
    ill = 1'b0;
    case (p)
      4'd0:  u = u3(0, 0, 0);
      4'd1:  u = u3(1, 0, 0);
      4'd2:  u = u3(1, 1, 0);
      4'd3:  u = u3(1, 0, 3);
      4'd4:  u = u3(1, 2, 0);
      4'd5:  u = u3(1, 1, 2);
      4'd6:  u = u3(1, 2, 3);
      4'd7:  u = u3(0, 0, 3);
      4'd8:  u = u3(1, 3, 3);
      4'd9:  u = u3(3, 3, 3);
      4'd10: begin u = u3(1, 0, 0); st[1] = 1'b1; end
      4'd11: begin u = u3(1, 1, 0); st[0] = 1'b1; end
      4'd12: u = u3(2, 2, 3);
      default: begin u = 6'd0; ill = 1'b1; end
    endcase
    if (!ill) st[2] = b[0];
    return {ill, st, ill ? 3'b000 : 3'b111, u, b[127:87], b[86:46], b[45:5]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] b, input bit want_immediate);
    bit first;
    @(negedge clk);
    in_valid  = 1'b1;
    in_bundle = b;
    first = 1'b1;
    forever begin
      #2;
      if (in_ready) break;
      first = 1'b0;
      @(negedge clk);
    end
    if (want_immediate) check(first, "R9 back-to-back accept", {135'd0, first}, 136'd1);
    @(posedge clk);
    exp_q.push_back(model(b));
    #1 in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [135:0] cur;
    logic [135:0] e;
    if (running) begin
      out_ready = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
      #1;
      cur = {out_illegal, out_stop, out_slot_vld, out_unit, out_slot};
      check(in_ready == (out_ready || !out_valid), "R8 in_ready rule",
            {135'd0, in_ready}, {135'd0, (out_ready || !out_valid)});
      if (prev_stall)
        check(out_valid && cur == prev_out, "R7 hold under stall", cur, prev_out);
      if (!rand_ready && exp_q.size() != 0)
        check(out_valid, "R9 one-cycle latency", {135'd0, out_valid}, 136'd1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected output", cur, 136'd0);
        end else begin
          e = exp_q.pop_front();
          check(cur == e, "R1-R6 decoded result", cur, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = cur;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] b;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R10 reset state",
          {134'd0, out_valid, in_ready}, 136'd1);
    running = 1'b1;
    // R1: distinct slot markers
    send({41'h0, 41'h0, 41'h1FFFFFFFFFF, 5'd2}, 1'b0);
    send({41'h0, 41'h1FFFFFFFFFF, 41'h0, 5'd2}, 1'b1);
    send({41'h1FFFFFFFFFF, 41'h0, 41'h0, 5'd3}, 1'b1);
    // R2..R6: sweep all templates back to back
    for (int t = 0; t < 32; t++) begin
      b = {$urandom, $urandom, $urandom, $urandom};
      b[4:0] = 5'(t);
      send(b, 1'b1);
    end
    repeat (3) @(posedge clk);
    // R7/R8: random ready and gaps
    rand_ready = 1'b1;
    for (int k = 0; k < 400; k++) begin
      b = {$urandom, $urandom, $urandom, $urandom};
      send(b, 1'b0);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(posedge clk);
    end
    rand_ready = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule